// File: doc/BRIEF.md
# Stall Watchdog and Redundancy-Select Search Controller

This block watches a set of phase-detector outputs taken from the registers of a self-timed pipeline. It decides that the pipeline has locked up when none of those outputs has moved for a set number of clock cycles. It then steps a wide redundancy-select word, one value at a time, until the pipeline shows activity again. The select word drives the routing inputs of the redundant cells in the pipeline. An all-zero word routes every cell through its nominal path, and each basic cell reads two bits of the word to choose between its nominal and spare inputs. The search has no knowledge of where the fault lies. It tries the next value of a counter after every timeout, and it keeps the value that was last applied as soon as the pipeline moves again.

Three pieces make up the block. An activity watchdog flags a timeout. A stall detector turns that timeout into a request. A sequencer advances the select word and acknowledges the request once the new word has had time to settle. The detector and the sequencer talk through a four-phase request/acknowledge handshake. While the handshake is in progress the watchdog is held at zero, so every retry waits for a full fresh timeout. If the select word wraps back to zero, every value has been tried, and a sticky flag reports that the fault cannot be repaired.

Stall detector states and transitions: DET_WATCH goes to DET_REQ on a watchdog expiry. DET_REQ goes to DET_DONE when the acknowledge is high. DET_DONE goes back to DET_WATCH when the acknowledge is low. Sequencer states and transitions: SEQ_IDLE goes to SEQ_STEP on a request. SEQ_STEP always goes to SEQ_SETTLE, and the word advances in that cycle. SEQ_SETTLE goes to SEQ_ACK after APPLY_LAT cycles. SEQ_ACK goes back to SEQ_IDLE when the request is low.

Top module: `stall_repair_ctrl`

## Requirements
- R1: After reset, cfg_word_o is all zeros (nominal path in every cell), and repair_req_o, repair_ack_o, stalled_o and unrecoverable_o are all 0.
- R2: Any bit change on phase_i, seen at a rising edge, clears the watchdog. If no more than TIMEOUT_CYC-1 quiet edges separate two such changes, no request is raised and cfg_word_o does not change.
- R3: Take edge 0 as the last edge that saw a phase_i change, with no change after it. repair_req_o and stalled_o are 0 after edge TIMEOUT_CYC-1 and 1 after edge TIMEOUT_CYC. cfg_word_o still holds its old value after edge TIMEOUT_CYC+1 and has moved after edge TIMEOUT_CYC+2.
- R4: Each request advances cfg_word_o by exactly one, modulo 2^CFG_W. The word never changes in any other way.
- R5: The handshake is four-phase. repair_ack_o rises after edge TIMEOUT_CYC+2+APPLY_LAT, while repair_req_o is still high. repair_req_o falls one edge later while repair_ack_o stays high. repair_ack_o falls one edge after that. repair_req_o stays high until it sees repair_ack_o.
- R6: While the pipeline stays stalled, the next word appears TIMEOUT_CYC+5+APPLY_LAT cycles after the previous one.
- R7: When activity returns, no further request is made and cfg_word_o keeps its value. A request that was already raised before activity returned still completes, and it adds exactly one step.
- R8: When cfg_word_o wraps from all ones to zero, unrecoverable_o goes to 1. It stays at 1 until reset, and the search continues.
- R9: stalled_o is 1 from the edge that raises the request until two edges after repair_req_o falls. It is 0 after edge TIMEOUT_CYC+5+APPLY_LAT of a stall. repair_req_o is never 1 while stalled_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | NUM_DET | Phase-detector states from the monitored pipeline registers |
| cfg_word_o | output | CFG_W | Redundancy-select word driven to the cells |
| repair_req_o | output | 1 | Request from the stall detector to the sequencer |
| repair_ack_o | output | 1 | Acknowledge from the sequencer once the new word has settled |
| stalled_o | output | 1 | Stall detector is outside its watching state |
| unrecoverable_o | output | 1 | Sticky flag: the select word has wrapped to zero |

## Verification
Several properties are checked on every cycle. The word only ever moves by one step, and only while a stall is being handled. The request and acknowledge hold their levels in four-phase order. A request never appears without a stall. The unrecoverable flag is sticky and rises together with a zero word. The watchdog stays below its limit. Some behaviour can only be shown by the bench scenarios, which count edges from the last phase change. These cover the exact cycles of the first and later word steps, the fact that phase changes spaced one timeout apart never trigger a request, the single step left over when activity returns in the middle of a request, and the wrap after every value has been tried.

// File: rtl/srq_pkg.sv
package srq_pkg;

    // Stall detector: watching, requesting a new word, waiting for ack release
    typedef enum logic [1:0] {
        DET_WATCH = 2'd0,
        DET_REQ   = 2'd1,
        DET_DONE  = 2'd2
    } det_state_e;

    // Sequencer: idle, advance word, settle, acknowledge
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STEP   = 2'd1,
        SEQ_SETTLE = 2'd2,
        SEQ_ACK    = 2'd3
    } seq_state_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 2) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/srq_activity_watch.sv
module srq_activity_watch #(
    parameter int NUM_DET     = 8,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_DET-1:0]   phase_i,
    input  logic                 arm_i,
    output logic                 expire_o,
    output logic [srq_pkg::cnt_width(TIMEOUT_CYC)-1:0] count_o
);
    localparam int CW = srq_pkg::cnt_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [NUM_DET-1:0] phase_q;
    logic [CW-1:0]      cnt_q;
    logic               activity;
    logic               at_last;

    // One change detector per monitored phase bit
    logic [NUM_DET-1:0] bit_moved;
    for (genvar g = 0; g < NUM_DET; g++) begin : g_edge
        assign bit_moved[g] = phase_i[g] ^ phase_q[g];
    end

    assign activity = |bit_moved;
    assign at_last  = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_i;
        end
    end

    // Counter is held at zero while the detector is busy with a handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm_i || activity || at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expire_o = arm_i && at_last && !activity;
    assign count_o  = cnt_q;

endmodule

// File: rtl/srq_stall_detector.sv
module srq_stall_detector (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic ack_i,
    output logic req_o,
    output logic stalled_o,
    output logic arm_o
);
    import srq_pkg::*;

    det_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_WATCH: if (expire_i) state_d = DET_REQ;
            DET_REQ:   if (ack_i)    state_d = DET_DONE;
            DET_DONE:  if (!ack_i)   state_d = DET_WATCH;
            default:                 state_d = DET_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DET_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        req_o     = 1'b0;
        stalled_o = 1'b1;
        arm_o     = 1'b0;
        unique case (state_q)
            DET_WATCH: begin
                stalled_o = 1'b0;
                arm_o     = 1'b1;
            end
            DET_REQ:   req_o = 1'b1;
            DET_DONE:  req_o = 1'b0;
            default: begin
                stalled_o = 1'b0;
                arm_o     = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/srq_cfg_sequencer.sv
module srq_cfg_sequencer #(
    parameter int CFG_W     = 34,
    parameter int APPLY_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    output logic             ack_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             unrec_o
);
    import srq_pkg::*;

    localparam int SW = cnt_width(APPLY_LAT);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(APPLY_LAT - 1);

    seq_state_e       state_q, state_d;
    logic [CFG_W-1:0] cfg_q;
    logic             unrec_q;
    logic [SW-1:0]    settle_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (req_i) state_d = SEQ_STEP;
            SEQ_STEP:   state_d = SEQ_SETTLE;
            SEQ_SETTLE: if (settle_q == SETTLE_LAST) state_d = SEQ_ACK;
            SEQ_ACK:    if (!req_i) state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Word counter, wrap flag and settle timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            unrec_q  <= 1'b0;
            settle_q <= '0;
        end else begin
            if (state_q == SEQ_STEP) begin
                cfg_q    <= cfg_q + CFG_W'(1);
                settle_q <= '0;
                if (&cfg_q) unrec_q <= 1'b1;
            end else if (state_q == SEQ_SETTLE) begin
                settle_q <= settle_q + SW'(1);
            end
        end
    end

    always_comb begin
        ack_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE, SEQ_STEP, SEQ_SETTLE: ack_o = 1'b0;
            SEQ_ACK:  ack_o = 1'b1;
            default:  ack_o = 1'b0;
        endcase
    end

    assign cfg_o   = cfg_q;
    assign unrec_o = unrec_q;

endmodule

// File: rtl/stall_repair_ctrl.sv
module stall_repair_ctrl #(
    parameter int NUM_DET     = 8,
    parameter int CFG_W       = 34,
    parameter int TIMEOUT_CYC = 1024,
    parameter int APPLY_LAT   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DET-1:0] phase_i,
    output logic [CFG_W-1:0]   cfg_word_o,
    output logic               repair_req_o,
    output logic               repair_ack_o,
    output logic               stalled_o,
    output logic               unrecoverable_o
);
    localparam int CW = srq_pkg::cnt_width(TIMEOUT_CYC);

    logic          expire;
    logic          arm;
    logic          req;
    logic          ack;
    logic [CW-1:0] wd_count;

    srq_activity_watch #(
        .NUM_DET     (NUM_DET),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase_i),
        .arm_i    (arm),
        .expire_o (expire),
        .count_o  (wd_count)
    );

    srq_stall_detector u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire),
        .ack_i     (ack),
        .req_o     (req),
        .stalled_o (stalled_o),
        .arm_o     (arm)
    );

    srq_cfg_sequencer #(
        .CFG_W     (CFG_W),
        .APPLY_LAT (APPLY_LAT)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .ack_o   (ack),
        .cfg_o   (cfg_word_o),
        .unrec_o (unrecoverable_o)
    );

    assign repair_req_o = req;
    assign repair_ack_o = ack;

endmodule

// File: rtl/stall_repair_chk.sv
module stall_repair_chk #(
    parameter int CFG_W       = 34,
    parameter int TIMEOUT_CYC = 1024,
    parameter int CW          = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg,
    input logic             req,
    input logic             ack,
    input logic             stalled,
    input logic             unrec,
    input logic [CW-1:0]    wd_count
);
    // R2: watchdog never passes its limit
    p_wd_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wd_count) < TIMEOUT_CYC);

    // R4: word moves only by a single step
    p_cfg_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> cfg == $past(cfg) + CFG_W'(1));

    // R7: word only moves while a stall is being handled
    p_cfg_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> stalled);

    // R5: request held until acknowledged
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);

    // R5: acknowledge held until request released
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> ack);

    // R5: acknowledge rises only against a live request
    p_ack_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> req);

    // R5: request falls only after acknowledge
    p_req_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> ack);

    // R8: unrecoverable flag is sticky
    p_unrec_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unrec |=> unrec);

    // R8: flag rises together with a wrapped word
    p_unrec_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unrec) |-> cfg == '0);

    // R9: no request outside a stall
    p_req_in_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> stalled);

endmodule

bind stall_repair_ctrl stall_repair_chk #(
    .CFG_W       (CFG_W),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CW          (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_word_o),
    .req      (repair_req_o),
    .ack      (repair_ack_o),
    .stalled  (stalled_o),
    .unrec    (unrecoverable_o),
    .wd_count (wd_count)
);

// File: tb/stall_repair_ctrl_tb.sv
`timescale 1ns/1ps
module stall_repair_ctrl_tb;
    localparam int NDET = 4;
    localparam int CW   = 6;
    localparam int T    = 16;
    localparam int L    = 2;
    localparam int P    = T + 5 + L;
    localparam int MODW = 1 << CW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NDET-1:0] ph = '0;
    logic [CW-1:0]   cfg;
    logic            req, ack, stalled, unrec;

    int n_run = 0;
    int n_fail = 0;
    int total = 0;   // committed steps since reset
    bit done = 0;

    always #2.5 clk = ~clk;

    stall_repair_ctrl #(
        .NUM_DET(NDET), .CFG_W(CW), .TIMEOUT_CYC(T), .APPLY_LAT(L)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .phase_i(ph), .cfg_word_o(cfg),
        .repair_req_o(req), .repair_ack_o(ack), .stalled_o(stalled),
        .unrecoverable_o(unrec)
    );

    // Steps visible after c quiet edges (R3, R6)
    function automatic int vis_steps(input int c);
        return (c < T + 2) ? 0 : 1 + (c - T - 2) / P;
    endfunction
    // Steps committed by c quiet edges (R7)
    function automatic int commit_steps(input int c);
        return (c < T) ? 0 : 1 + (c - T) / P;
    endfunction

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ph = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        total = 0;
    endtask

    // Toggle at least one phase bit each cycle; ends at negedge after last clearing edge
    task automatic burst(input int len);
        for (int i = 0; i < len; i++) begin
            logic [NDET-1:0] m;
            m = NDET'($urandom);
            if (m == '0) m = 1;
            ph = ph ^ m;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int c);
        repeat (c) @(negedge clk);
    endtask

    initial begin
        int limit;
        limit = 0;
        while (!done && limit < 150000) begin
            @(posedge clk);
            limit++;
        end
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual %0d expected %0d", limit, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        process::self().srandom(32'd20240611);
        do_reset();
        @(negedge clk);
        // R1
        chk("R1", "cfg", cfg, 0);
        chk("R1", "req", req, 0);
        chk("R1", "ack", ack, 0);
        chk("R1", "stalled", stalled, 0);
        chk("R1", "unrec", unrec, 0);

        // Exact timing of one stall
        burst(10);
        base = 0;
        for (int c = 1; c <= T + P + 2; c++) begin
            @(negedge clk);
            if (c == T - 1) begin
                chk("R3", "req before timeout", req, 0);
                chk("R3", "stalled before timeout", stalled, 0);
            end
            if (c == T) begin
                chk("R3", "req at timeout", req, 1);
                chk("R9", "stalled at timeout", stalled, 1);
            end
            if (c == T + 1) chk("R3", "cfg before step", cfg, base);
            if (c == T + 2) chk("R4", "cfg after step", cfg, base + 1);
            if (c == T + 2 + L) begin
                chk("R5", "ack rise", ack, 1);
                chk("R5", "req with ack", req, 1);
            end
            if (c == T + 3 + L) begin
                chk("R5", "req released", req, 0);
                chk("R5", "ack held", ack, 1);
            end
            if (c == T + 4 + L) begin
                chk("R5", "ack released", ack, 0);
                chk("R9", "stalled during release", stalled, 1);
            end
            if (c == T + 5 + L) chk("R9", "stalled cleared", stalled, 0);
            if (c == T + P + 1) chk("R6", "cfg before 2nd step", cfg, base + 1);
            if (c == T + P + 2) chk("R6", "cfg 2nd step", cfg, base + 2);
        end
        total = 2 + ((commit_steps(T + P + 2) > 2) ? 1 : 0);
        burst(20);
        chk("R7", "cfg kept after resume", cfg, total % MODW);

        // R2: one change every T cycles never trips the watchdog
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 12; k++) begin
                ph[0] = ~ph[0];
                for (int j = 0; j < T; j++) begin
                    @(negedge clk);
                    if (req) seen++;
                end
            end
            chk("R2", "requests with spaced changes", seen, 0);
            chk("R2", "cfg with spaced changes", cfg, total % MODW);
        end

        // R7: resume just after the request was raised
        burst(5);
        quiet(T + 1);
        chk("R7", "cfg mid-request", cfg, total % MODW);
        chk("R7", "req mid-request", req, 1);
        burst(20);
        total += 1;
        chk("R7", "single pending step", cfg, total % MODW);
        burst(3 * P);
        chk("R7", "no more steps", cfg, total % MODW);

        // R8: wrap of the word
        do_reset();
        burst(5);
        quiet(T + 2 + 62 * P);
        chk("R8", "cfg at all ones", cfg, MODW - 1);
        chk("R8", "unrec before wrap", unrec, 0);
        quiet(P);
        chk("R8", "cfg wrapped", cfg, 0);
        chk("R8", "unrec after wrap", unrec, 1);
        quiet(P);
        chk("R8", "search continues", cfg, 1);
        chk("R8", "unrec sticky", unrec, 1);
        do_reset();
        @(negedge clk);
        chk("R1", "unrec cleared by reset", unrec, 0);
        chk("R1", "cfg cleared by reset", cfg, 0);

        // Random stalls and bursts
        burst(8);
        for (int it = 0; it < 30; it++) begin
            int c;
            int v;
            c = $urandom_range(0, T + 3 * P);
            quiet(c);
            v = total + vis_steps(c);
            chk("R6", "cfg after random stall", cfg, v % MODW);
            chk("R8", "unrec after random stall", unrec, (v >= MODW) ? 1 : 0);
            total += commit_steps(c);
            burst($urandom_range(12, 30));
            chk("R7", "cfg after random burst", cfg, total % MODW);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule